// File: doc/BRIEF.md
# Shared-Path Bit-Manipulation ALU

This block is the integer execution datapath of a 64-bit core. It is purely combinational: two operands and a handful of already-decoded control fields go in, and a result and a less-than flag come out in the same cycle. One set of and/or/xor gates, one adder, one funnel shifter, one comparator and one bit counter serve four operation families:

- the base arithmetic and logic operations;
- shift-and-add address generation;
- basic bit manipulation (rotates, negated logic, extension, byte operations, min/max, counts);
- single-bit set, clear, invert and extract.

The decode stage drives the control fields:

- a unit select;
- a three-bit function select that keeps the base function-code meaning;
- a bit-manipulation sub-select;
- a two-bit variant taken from the low bits of the instruction's rs2 field;
- an invert flag;
- a word flag;
- an ALU-op flag.

Negated logic and bit clear reuse the base logic gates with the second operand inverted. Bit extract reuses the right-shift path.

Top module: `bitmanip_alu`

## Requirements
- R1: With `aluop_i` low and unit 00 (base), the result is the full-width sum a+b. The function select, invert flag and word flag have no effect.
- R2: Base unit (00) with `aluop_i` high uses the function select as follows:
  - 000: add, or subtract a-b when `inv_i` is set.
  - 001: shift left.
  - 010: signed set-less-than (result 0 or 1).
  - 011: unsigned set-less-than (result 0 or 1).
  - 100: xor.
  - 101: logical right shift, or arithmetic right shift when `inv_i` is set.
  - 110: or.
  - 111: and.
  - The shift amount is b[5:0].
- R3: `cmp_o` is 1 exactly when a<b. The compare is signed when fsel[0]=0 and unsigned when fsel[0]=1, in every unit.
- R4: When `word_i` and `aluop_i` are both high in the base or bitmanip unit, the operation works on the low 32 bits and the result is sign-extended from bit 31. Word shifts use b[4:0], and a word arithmetic right shift fills from bit 31.
- R5: With `inv_i` set, function select 111 gives a AND NOT b, 110 gives a OR NOT b, and 100 gives NOT(a XOR b). This holds in the base unit and in bitmanip sub-select 111.
- R6: Address unit (01) uses the function select as follows:
  - 010, 100, 110: (a<<1), (a<<2), (a<<3) plus b.
  - 000: a+b.
  - 001: a<<b[5:0].
  - `word_i` replaces a by its zero-extended low 32 bits first, and the result is not sign-extended.
- R7: Bitmanip sub-select 111 with function select 001 rotates a left by b[5:0]; with 101 it rotates right. Under `word_i` the rotate is over the low 32 bits by b[4:0].
- R8: Bitmanip sub-select 100 performs extension:
  - Function select 100 zero-extends a[15:0].
  - Otherwise variant bit 0 = 0 sign-extends a[7:0], and = 1 sign-extends a[15:0].
- R9: Bitmanip sub-select 011 works on bytes:
  - Variant bit 0 = 0 reverses the byte order of a.
  - Variant bit 0 = 1 sets each result byte to FF if the matching byte of a is nonzero, else 00.
- R10: Bitmanip sub-select 101 returns the maximum of a and b, and 110 returns the minimum. The compare is signed when fsel[0]=0 and unsigned when fsel[0]=1.
- R11: Bitmanip sub-select 000 counts bits, selected by the variant:
  - 00: leading zeros.
  - 01: trailing zeros.
  - 1x: set bits.
  - Under `word_i` only a[31:0] is counted. An all-zero input gives 64, or 32 in word mode.
- R12: Single-bit unit (11) uses the mask 1<<b[5:0]:
  - Function select 111 with `inv_i` clears that bit of a.
  - 110 sets it.
  - 100 inverts it.
  - 101 with `inv_i` returns bit b[5:0] of a in bit 0, with zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand, shift amount or bit index |
| fsel_i | input | 3 | Function select (base function-code meaning) |
| unit_i | input | 2 | 00 base, 01 address, 10 bitmanip, 11 single-bit |
| bsub_i | input | 3 | Bitmanip sub-select |
| xsel_i | input | 2 | Variant from the low rs2 field bits |
| inv_i | input | 1 | Invert second operand / subtract / arithmetic |
| word_i | input | 1 | 32-bit word operation |
| aluop_i | input | 1 | Function select is honoured in the base unit |
| result_o | output | 64 | Result |
| cmp_o | output | 1 | a less than b |

## Verification
Rotates by zero are exercised. A design that forms the wrap-around term with a full-width shift would return wrong bits there. Word operations use operands whose bit 31 is set while the upper half differs, so a missed sign extension, or a right shift that takes its fill from bit 63, shows up at once. Counts on zero in both widths catch a counter that reports 63 or 31. Bit extract at index 63 and index 0, and compares across the sign boundary, catch a swapped signed/unsigned choice. Min/max and set-less-than would then pick the wrong operand.

// File: rtl/bmalu_pkg.sv
// Shared encodings for the shared-path bit-manipulation ALU.
package bmalu_pkg;

    // Operation family driven by the decoder.
    typedef enum logic [1:0] {
        UNIT_BASE   = 2'b00,
        UNIT_ADDR   = 2'b01,
        UNIT_BMANIP = 2'b10,
        UNIT_SBIT   = 2'b11
    } unit_e;

    // Bitmanip sub-select codes.
    localparam logic [2:0] BS_COUNT  = 3'b000;
    localparam logic [2:0] BS_BYTE   = 3'b011;
    localparam logic [2:0] BS_EXT    = 3'b100;
    localparam logic [2:0] BS_MAX    = 3'b101;
    localparam logic [2:0] BS_MIN    = 3'b110;
    localparam logic [2:0] BS_ROTLOG = 3'b111;

    // Function select codes (base function-code meaning).
    localparam logic [2:0] F_ADD  = 3'b000;
    localparam logic [2:0] F_SHL  = 3'b001;
    localparam logic [2:0] F_SLT  = 3'b010;
    localparam logic [2:0] F_SLTU = 3'b011;
    localparam logic [2:0] F_XOR  = 3'b100;
    localparam logic [2:0] F_SHR  = 3'b101;
    localparam logic [2:0] F_OR   = 3'b110;
    localparam logic [2:0] F_AND  = 3'b111;

endpackage

// File: rtl/bmalu_shifter.sv
// Funnel shifter: left/right, logical/arithmetic, and rotate.
// Left operations bit-reverse the input, shift right, then reverse back.
// Assumes amt < XLEN; rotate fill is the operand itself.
module bmalu_shifter #(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] src,
    input  logic [SHW-1:0]  amt,
    input  logic            left,
    input  logic            arith,
    input  logic            rotate,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0]   src_rev;
    logic [XLEN-1:0]   pre;
    logic [XLEN-1:0]   fill;
    logic [2*XLEN-1:0] ext;
    logic [2*XLEN-1:0] shifted;
    logic [XLEN-1:0]   low;
    logic [XLEN-1:0]   low_rev;

    // Bit reversal networks for the left-shift direction.
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign src_rev[i] = src[XLEN-1-i];
        assign low_rev[i] = low[XLEN-1-i];
    end

    // Build the double-width funnel and shift it right.
    always_comb begin
        pre     = left ? src_rev : src;
        fill    = rotate ? pre : {XLEN{arith & pre[XLEN-1]}};
        ext     = {fill, pre};
        shifted = ext >> amt;
        low     = shifted[XLEN-1:0];
    end

    assign res = left ? low_rev : low;
endmodule

// File: rtl/bmalu_counter.sv
// Leading-zero, trailing-zero and population count.
// In word mode only the low half is considered; padding makes an all-zero
// half count as XLEN/2.
module bmalu_counter #(
    parameter int XLEN = 64,
    localparam int W  = XLEN / 2,
    localparam int CW = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] src,
    input  logic            word,
    input  logic [1:0]      mode,
    output logic [CW-1:0]   cnt
);
    logic [XLEN-1:0] lz_v;
    logic [XLEN-1:0] tz_v;
    logic [XLEN-1:0] pc_v;
    logic [CW-1:0]   lz_c;
    logic [CW-1:0]   tz_c;
    logic [CW-1:0]   pc_c;

    // Pad the operand so that word counts stop at the half boundary.
    always_comb begin
        lz_v = word ? {src[W-1:0], {W{1'b1}}} : src;
        tz_v = word ? {{W{1'b1}}, src[W-1:0]} : src;
        pc_v = word ? {{W{1'b0}}, src[W-1:0]} : src;
    end

    // Leading zeros: the highest set bit found wins.
    always_comb begin
        lz_c = CW'(XLEN);
        for (int i = 0; i < XLEN; i++)
            if (lz_v[i]) lz_c = CW'(XLEN - 1 - i);
    end

    // Trailing zeros: the lowest set bit found wins.
    always_comb begin
        tz_c = CW'(XLEN);
        for (int i = XLEN - 1; i >= 0; i--)
            if (tz_v[i]) tz_c = CW'(i);
    end

    // Population count.
    always_comb begin
        pc_c = '0;
        for (int i = 0; i < XLEN; i++)
            pc_c = pc_c + CW'(pc_v[i]);
    end

    // Select the requested count.
    always_comb begin
        case (mode)
            2'b00:   cnt = lz_c;
            2'b01:   cnt = tz_c;
            default: cnt = pc_c;
        endcase
    end
endmodule

// File: rtl/bmalu_compare.sv
// Less-than comparator shared by set-less-than, min and max.
// Splits off the sign bit so one magnitude compare serves both signednesses.
module bmalu_compare #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_unsigned,
    output logic            lt
);
    logic low_lt;
    logic msb_diff;

    // Compare the magnitudes below the top bit, then resolve by the sign.
    always_comb begin
        low_lt   = a[XLEN-2:0] < b[XLEN-2:0];
        msb_diff = a[XLEN-1] ^ b[XLEN-1];
        if (!msb_diff)        lt = low_lt;
        else if (is_unsigned) lt = b[XLEN-1];
        else                  lt = a[XLEN-1];
    end
endmodule

// File: rtl/bitmanip_alu.sv
// Combinational integer ALU. Base, address-generation, basic bitmanip and
// single-bit operations share one logic array, one adder, one funnel
// shifter, one comparator and one counter. Control fields arrive decoded;
// the invert flag turns the shared paths into subtract, arithmetic shift,
// andn/orn/xnor and bit clear. Assumes XLEN is 64 (word = low half).
module bitmanip_alu #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [2:0]      fsel_i,
    input  logic [1:0]      unit_i,
    input  logic [2:0]      bsub_i,
    input  logic [1:0]      xsel_i,
    input  logic            inv_i,
    input  logic            word_i,
    input  logic            aluop_i,
    output logic [XLEN-1:0] result_o,
    output logic            cmp_o
);
    import bmalu_pkg::*;

    localparam int SHW = $clog2(XLEN);
    localparam int W   = XLEN / 2;
    localparam int CW  = SHW + 1;
    localparam int NB  = XLEN / 8;

    unit_e           unit;
    logic            is_base, is_addr, is_bm, is_sbit;
    logic            inv_eff;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] b_src, b_log;
    logic [XLEN-1:0] and_r, or_r, xor_r, logic_r;
    logic [XLEN-1:0] a_zx, a_sx, a_pre;
    logic [1:0]      add_k;
    logic            sub;
    logic [XLEN-1:0] add_a, add_b, sum;
    logic [XLEN-1:0] sh_src, sh_res;
    logic [SHW-1:0]  sh_amt;
    logic            sh_left, sh_arith;
    logic [CW-1:0]   cnt;
    logic [XLEN-1:0] ext_r, rev_r, orc_r, mm_r;
    logic [XLEN-1:0] res_pre;
    logic            lt;

    // Decode the unit select into one-hot qualifiers.
    always_comb begin
        unit    = unit_e'(unit_i);
        is_base = unit == UNIT_BASE;
        is_addr = unit == UNIT_ADDR;
        is_bm   = unit == UNIT_BMANIP;
        is_sbit = unit == UNIT_SBIT;
        inv_eff = inv_i & aluop_i;
    end

    // Second operand for the logic array: one-hot mask in single-bit mode,
    // optionally inverted after the mask is built.
    always_comb begin
        mask  = {{(XLEN-1){1'b0}}, 1'b1} << b_i[SHW-1:0];
        b_src = is_sbit ? mask : b_i;
        b_log = inv_eff ? ~b_src : b_src;
    end

    // Shared logic array and its function-select mux.
    always_comb begin
        and_r = a_i & b_log;
        or_r  = a_i | b_log;
        xor_r = a_i ^ b_log;
        case (fsel_i)
            F_AND:   logic_r = and_r;
            F_OR:    logic_r = or_r;
            default: logic_r = xor_r;
        endcase
    end

    // Operand A variants for word and unsigned-word forms.
    always_comb begin
        a_zx  = {{(XLEN-W){1'b0}}, a_i[W-1:0]};
        a_sx  = {{(XLEN-W){a_i[W-1]}}, a_i[W-1:0]};
        a_pre = word_i ? a_zx : a_i;
    end

    // Shared adder: add, subtract, shift-and-add.
    always_comb begin
        case (fsel_i)
            3'b010:  add_k = 2'd1;
            3'b100:  add_k = 2'd2;
            3'b110:  add_k = 2'd3;
            default: add_k = 2'd0;
        endcase
        sub   = is_base & inv_eff & (fsel_i == F_ADD);
        add_a = is_addr ? (a_pre << add_k) : a_i;
        add_b = sub ? ~b_i : b_i;
        sum   = add_a + add_b + XLEN'(sub);
    end

    // Shifter operand, amount and mode per unit.
    always_comb begin
        sh_left  = (fsel_i == F_SHL) & ~is_sbit;
        sh_arith = is_base & inv_eff;
        if (word_i & ~is_addr)
            sh_amt = SHW'(b_i[SHW-2:0]);
        else
            sh_amt = b_i[SHW-1:0];
        case (unit)
            UNIT_BASE:   sh_src = (word_i & ~sh_left) ? (sh_arith ? a_sx : a_zx) : a_i;
            UNIT_ADDR:   sh_src = a_pre;
            UNIT_BMANIP: sh_src = word_i ? {a_i[W-1:0], a_i[W-1:0]} : a_i;
            default:     sh_src = a_i;
        endcase
    end

    bmalu_shifter #(.XLEN(XLEN)) u_shift (
        .src    (sh_src),
        .amt    (sh_amt),
        .left   (sh_left),
        .arith  (sh_arith),
        .rotate (is_bm),
        .res    (sh_res)
    );

    bmalu_compare #(.XLEN(XLEN)) u_cmp (
        .a           (a_i),
        .b           (b_i),
        .is_unsigned (fsel_i[0]),
        .lt          (lt)
    );

    bmalu_counter #(.XLEN(XLEN)) u_cnt (
        .src  (a_i),
        .word (word_i),
        .mode (xsel_i),
        .cnt  (cnt)
    );

    // Byte reverse and OR-combine, one lane per byte.
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign rev_r[8*i +: 8] = a_i[8*(NB-1-i) +: 8];
        assign orc_r[8*i +: 8] = {8{|a_i[8*i +: 8]}};
    end

    // Extension and min/max selection.
    always_comb begin
        if (fsel_i == F_XOR)
            ext_r = {{(XLEN-16){1'b0}}, a_i[15:0]};
        else if (xsel_i[0])
            ext_r = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
        else
            ext_r = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
        if (bsub_i == BS_MAX)
            mm_r = lt ? b_i : a_i;
        else
            mm_r = lt ? a_i : b_i;
    end

    // Result mux by unit, function select and sub-select.
    always_comb begin
        res_pre = '0;
        case (unit)
            UNIT_BASE: begin
                if (!aluop_i) res_pre = sum;
                else begin
                    case (fsel_i)
                        F_ADD:         res_pre = sum;
                        F_SHL, F_SHR:  res_pre = sh_res;
                        F_SLT, F_SLTU: res_pre = {{(XLEN-1){1'b0}}, lt};
                        default:       res_pre = logic_r;
                    endcase
                end
            end
            UNIT_ADDR: res_pre = (fsel_i == F_SHL) ? sh_res : sum;
            UNIT_BMANIP: begin
                case (bsub_i)
                    BS_ROTLOG: res_pre = (fsel_i == F_SHL || fsel_i == F_SHR) ? sh_res : logic_r;
                    BS_EXT:    res_pre = ext_r;
                    BS_BYTE:   res_pre = xsel_i[0] ? orc_r : rev_r;
                    BS_MAX,
                    BS_MIN:    res_pre = mm_r;
                    BS_COUNT:  res_pre = {{(XLEN-CW){1'b0}}, cnt};
                    default:   res_pre = '0;
                endcase
            end
            default: begin
                if (fsel_i == F_SHR) res_pre = {{(XLEN-1){1'b0}}, sh_res[0]};
                else                 res_pre = logic_r;
            end
        endcase
    end

    // Word results of base and bitmanip units are sign-extended from bit 31.
    always_comb begin
        if (word_i & aluop_i & (is_base | is_bm))
            result_o = {{(XLEN-W){res_pre[W-1]}}, res_pre[W-1:0]};
        else
            result_o = res_pre;
        cmp_o = lt;
    end
endmodule

// File: rtl/bitmanip_alu_checker.sv
// Port-level assertions for bitmanip_alu, attached with bind.
// The block is combinational, so every check is an immediate assertion
// evaluated whenever the ports change.
module bitmanip_alu_checker #(
    parameter int XLEN = 64,
    localparam int W = XLEN / 2
) (
    input logic [XLEN-1:0] a_i,
    input logic [XLEN-1:0] b_i,
    input logic [2:0]      fsel_i,
    input logic [1:0]      unit_i,
    input logic [2:0]      bsub_i,
    input logic            word_i,
    input logic            aluop_i,
    input logic [XLEN-1:0] result_o,
    input logic            cmp_o
);
    // Relate outputs to operands for each checkable requirement.
    always_comb begin
        if (!aluop_i && unit_i == 2'b00)
            p_plain_sum_r1: assert (result_o == a_i + b_i)
                else $error("plain add mismatch");
        if (fsel_i[0])
            p_cmp_unsigned_r3: assert (cmp_o == (a_i < b_i))
                else $error("unsigned compare mismatch");
        else
            p_cmp_signed_r3: assert (cmp_o == ($signed(a_i) < $signed(b_i)))
                else $error("signed compare mismatch");
        if (word_i && aluop_i && (unit_i == 2'b00 || unit_i == 2'b10))
            p_word_sext_r4: assert (result_o[XLEN-1:W] == {(XLEN-W){result_o[W-1]}})
                else $error("word result not sign-extended");
        if (unit_i == 2'b10 && bsub_i == 3'b000)
            p_count_range_r11: assert (result_o <= XLEN)
                else $error("count out of range");
        if (unit_i == 2'b11 && fsel_i == 3'b101)
            p_extract_onebit_r12: assert (result_o[XLEN-1:1] == '0)
                else $error("extract wider than one bit");
    end
endmodule

bind bitmanip_alu bitmanip_alu_checker #(.XLEN(XLEN)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .fsel_i   (fsel_i),
    .unit_i   (unit_i),
    .bsub_i   (bsub_i),
    .word_i   (word_i),
    .aluop_i  (aluop_i),
    .result_o (result_o),
    .cmp_o    (cmp_o)
);

// File: tb/bitmanip_alu_bench.sv
// Self-checking bench: a behavioural model per operation, compared every clock.
module bitmanip_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a, b;
    logic [2:0]  fsel, bsub;
    logic [1:0]  unit, xsel;
    logic        inv, word, aluop;
    logic [63:0] result;
    logic        cmp;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    bitmanip_alu u_bitmanip_alu (
        .a_i(a), .b_i(b), .fsel_i(fsel), .unit_i(unit), .bsub_i(bsub),
        .xsel_i(xsel), .inv_i(inv), .word_i(word), .aluop_i(aluop),
        .result_o(result), .cmp_o(cmp)
    );

    localparam int OP_ADD=0, OP_SUB=1, OP_SLL=2, OP_SLT=3, OP_SLTU=4, OP_XOR=5,
        OP_SRL=6, OP_SRA=7, OP_OR=8, OP_AND=9, OP_ADDW=10, OP_SUBW=11, OP_SLLW=12,
        OP_SRLW=13, OP_SRAW=14, OP_PLAIN=15, OP_SH1=16, OP_SH2=17, OP_SH3=18,
        OP_ADDUW=19, OP_SH1UW=20, OP_SH3UW=21, OP_SLLIUW=22, OP_ROL=23, OP_ROR=24,
        OP_ROLW=25, OP_RORW=26, OP_ANDN=27, OP_ORN=28, OP_XNOR=29, OP_SEXTB=30,
        OP_SEXTH=31, OP_ZEXTH=32, OP_REV8=33, OP_ORCB=34, OP_MAX=35, OP_MAXU=36,
        OP_MIN=37, OP_MINU=38, OP_CLZ=39, OP_CTZ=40, OP_CPOP=41, OP_CLZW=42,
        OP_CTZW=43, OP_CPOPW=44, OP_BCLR=45, OP_BSET=46, OP_BINV=47, OP_BEXT=48,
        NOPS=49;

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic string req_of(input int op);
        if (op == OP_PLAIN) return "R1";
        if (op >= OP_ADDW && op <= OP_SRAW) return "R4";
        if (op <= OP_AND) return "R2";
        if (op <= OP_SLLIUW) return "R6";
        if (op <= OP_RORW) return "R7";
        if (op <= OP_XNOR) return "R5";
        if (op <= OP_ZEXTH) return "R8";
        if (op <= OP_ORCB) return "R9";
        if (op <= OP_MINU) return "R10";
        if (op <= OP_CPOPW) return "R11";
        return "R12";
    endfunction

    // Control encodings from the requirements.
    task automatic set_ctrl(input int op);
        fsel = 3'b000; unit = 2'b00; bsub = 3'b000; xsel = 2'b00;
        inv = 1'b0; word = 1'b0; aluop = 1'b1;
        case (op)
            OP_ADD: ;
            OP_SUB:  inv = 1'b1;
            OP_SLL:  fsel = 3'b001;
            OP_SLT:  begin fsel = 3'b010; inv = 1'b1; end
            OP_SLTU: begin fsel = 3'b011; inv = 1'b1; end
            OP_XOR:  fsel = 3'b100;
            OP_SRL:  fsel = 3'b101;
            OP_SRA:  begin fsel = 3'b101; inv = 1'b1; end
            OP_OR:   fsel = 3'b110;
            OP_AND:  fsel = 3'b111;
            OP_ADDW: word = 1'b1;
            OP_SUBW: begin word = 1'b1; inv = 1'b1; end
            OP_SLLW: begin word = 1'b1; fsel = 3'b001; end
            OP_SRLW: begin word = 1'b1; fsel = 3'b101; end
            OP_SRAW: begin word = 1'b1; fsel = 3'b101; inv = 1'b1; end
            OP_PLAIN: begin aluop = 1'b0; fsel = 3'b111; inv = 1'b1; word = 1'b1; end
            OP_SH1:  begin unit = 2'b01; fsel = 3'b010; end
            OP_SH2:  begin unit = 2'b01; fsel = 3'b100; end
            OP_SH3:  begin unit = 2'b01; fsel = 3'b110; end
            OP_ADDUW: begin unit = 2'b01; word = 1'b1; end
            OP_SH1UW: begin unit = 2'b01; fsel = 3'b010; word = 1'b1; end
            OP_SH3UW: begin unit = 2'b01; fsel = 3'b110; word = 1'b1; end
            OP_SLLIUW: begin unit = 2'b01; fsel = 3'b001; word = 1'b1; end
            OP_ROL:  begin unit = 2'b10; bsub = 3'b111; fsel = 3'b001; end
            OP_ROR:  begin unit = 2'b10; bsub = 3'b111; fsel = 3'b101; end
            OP_ROLW: begin unit = 2'b10; bsub = 3'b111; fsel = 3'b001; word = 1'b1; end
            OP_RORW: begin unit = 2'b10; bsub = 3'b111; fsel = 3'b101; word = 1'b1; end
            OP_ANDN: begin unit = 2'b10; bsub = 3'b111; fsel = 3'b111; inv = 1'b1; end
            OP_ORN:  begin unit = 2'b10; bsub = 3'b111; fsel = 3'b110; inv = 1'b1; end
            OP_XNOR: begin unit = 2'b10; bsub = 3'b111; fsel = 3'b100; inv = 1'b1; end
            OP_SEXTB: begin unit = 2'b10; bsub = 3'b100; fsel = 3'b001; xsel = 2'b00; end
            OP_SEXTH: begin unit = 2'b10; bsub = 3'b100; fsel = 3'b001; xsel = 2'b01; end
            OP_ZEXTH: begin unit = 2'b10; bsub = 3'b100; fsel = 3'b100; end
            OP_REV8: begin unit = 2'b10; bsub = 3'b011; fsel = 3'b101; xsel = 2'b00; end
            OP_ORCB: begin unit = 2'b10; bsub = 3'b011; fsel = 3'b101; xsel = 2'b11; end
            OP_MAX:  begin unit = 2'b10; bsub = 3'b101; fsel = 3'b110; end
            OP_MAXU: begin unit = 2'b10; bsub = 3'b101; fsel = 3'b111; end
            OP_MIN:  begin unit = 2'b10; bsub = 3'b110; fsel = 3'b100; end
            OP_MINU: begin unit = 2'b10; bsub = 3'b110; fsel = 3'b101; end
            OP_CLZ:  begin unit = 2'b10; fsel = 3'b001; xsel = 2'b00; end
            OP_CTZ:  begin unit = 2'b10; fsel = 3'b001; xsel = 2'b01; end
            OP_CPOP: begin unit = 2'b10; fsel = 3'b001; xsel = 2'b10; end
            OP_CLZW: begin unit = 2'b10; fsel = 3'b001; xsel = 2'b00; word = 1'b1; end
            OP_CTZW: begin unit = 2'b10; fsel = 3'b001; xsel = 2'b01; word = 1'b1; end
            OP_CPOPW: begin unit = 2'b10; fsel = 3'b001; xsel = 2'b10; word = 1'b1; end
            OP_BCLR: begin unit = 2'b11; fsel = 3'b111; inv = 1'b1; end
            OP_BSET: begin unit = 2'b11; fsel = 3'b110; end
            OP_BINV: begin unit = 2'b11; fsel = 3'b100; end
            default: begin unit = 2'b11; fsel = 3'b101; inv = 1'b1; end
        endcase
    endtask

    function automatic logic [63:0] model(input int op, input logic [63:0] x, input logic [63:0] y);
        logic [63:0] r;
        logic [31:0] w;
        logic [63:0] zx;
        int s, n;
        bit done;
        r = '0;
        zx = {32'b0, x[31:0]};
        s = int'(y[5:0]);
        case (op)
            OP_ADD, OP_PLAIN: r = x + y;
            OP_SUB:  r = x - y;
            OP_SLL:  r = x << s;
            OP_SLT:  r = ($signed(x) < $signed(y)) ? 64'd1 : 64'd0;
            OP_SLTU: r = (x < y) ? 64'd1 : 64'd0;
            OP_XOR:  r = x ^ y;
            OP_SRL:  r = x >> s;
            OP_SRA:  r = $signed(x) >>> s;
            OP_OR:   r = x | y;
            OP_AND:  r = x & y;
            OP_ADDW: begin w = x[31:0] + y[31:0]; r = sx32(w); end
            OP_SUBW: begin w = x[31:0] - y[31:0]; r = sx32(w); end
            OP_SLLW: begin w = x[31:0] << y[4:0]; r = sx32(w); end
            OP_SRLW: begin w = x[31:0] >> y[4:0]; r = sx32(w); end
            OP_SRAW: begin w = $signed(x[31:0]) >>> y[4:0]; r = sx32(w); end
            OP_SH1:  r = (x << 1) + y;
            OP_SH2:  r = (x << 2) + y;
            OP_SH3:  r = (x << 3) + y;
            OP_ADDUW: r = zx + y;
            OP_SH1UW: r = (zx << 1) + y;
            OP_SH3UW: r = (zx << 3) + y;
            OP_SLLIUW: r = zx << s;
            OP_ROL:  r = (x << s) | (x >> (64 - s));
            OP_ROR:  r = (x >> s) | (x << (64 - s));
            OP_ROLW: begin n = int'(y[4:0]); w = (x[31:0] << n) | (x[31:0] >> (32 - n)); r = sx32(w); end
            OP_RORW: begin n = int'(y[4:0]); w = (x[31:0] >> n) | (x[31:0] << (32 - n)); r = sx32(w); end
            OP_ANDN: r = x & ~y;
            OP_ORN:  r = x | ~y;
            OP_XNOR: r = ~(x ^ y);
            OP_SEXTB: r = {{56{x[7]}}, x[7:0]};
            OP_SEXTH: r = {{48{x[15]}}, x[15:0]};
            OP_ZEXTH: r = {48'b0, x[15:0]};
            OP_REV8: for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
            OP_ORCB: for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] != 0) ? 8'hFF : 8'h00;
            OP_MAX:  r = ($signed(x) > $signed(y)) ? x : y;
            OP_MAXU: r = (x > y) ? x : y;
            OP_MIN:  r = ($signed(x) < $signed(y)) ? x : y;
            OP_MINU: r = (x < y) ? x : y;
            OP_CLZ, OP_CLZW: begin
                n = 0; done = 0;
                for (int i = (op == OP_CLZ) ? 63 : 31; i >= 0; i--)
                    if (!done) begin if (x[i]) done = 1; else n++; end
                r = 64'(n);
            end
            OP_CTZ, OP_CTZW: begin
                n = 0; done = 0;
                for (int i = 0; i < ((op == OP_CTZ) ? 64 : 32); i++)
                    if (!done) begin if (x[i]) done = 1; else n++; end
                r = 64'(n);
            end
            OP_CPOP:  r = 64'($countones(x));
            OP_CPOPW: r = 64'($countones(x[31:0]));
            OP_BCLR: r = x & ~(64'd1 << s);
            OP_BSET: r = x | (64'd1 << s);
            OP_BINV: r = x ^ (64'd1 << s);
            default: r = {63'b0, x[s]};
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input int op, input logic [63:0] x, input logic [63:0] y);
        logic exp_cmp;
        @(negedge clk);
        set_ctrl(op);
        a = x; b = y;
        #2;
        check(req_of(op), result, model(op, x, y), $sformatf("op=%0d a=%h b=%h", op, x, y));
        exp_cmp = fsel[0] ? (x < y) : ($signed(x) < $signed(y));
        check("R3", {63'b0, cmp}, {63'b0, exp_cmp}, $sformatf("cmp op=%0d", op));
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        a = '0; b = '0;
        set_ctrl(OP_ADD);
        repeat (3) @(posedge clk);
        #2;
        check("R2", result, 64'd0, "idle result with zero operands");
        check("R3", {63'b0, cmp}, 64'd0, "idle compare with zero operands");
        rst_n = 1'b1;

        // Hand-computed boundary values.
        apply(OP_CLZ, 64'd0, 64'd0);
        check("R11", result, 64'd64, "clz of zero");
        apply(OP_CTZW, 64'hFFFF_FFFF_0000_0000, 64'd0);
        check("R11", result, 64'd32, "ctzw of zero low half");
        apply(OP_SEXTB, 64'h0000_0000_0000_0080, 64'd0);
        check("R8", result, 64'hFFFF_FFFF_FFFF_FF80, "sign-extend byte");
        apply(OP_REV8, 64'h0102_0304_0506_0708, 64'd0);
        check("R9", result, 64'h0807_0605_0403_0201, "byte reverse");
        apply(OP_BEXT, 64'h8000_0000_0000_0000, 64'd63);
        check("R12", result, 64'd1, "extract top bit");
        apply(OP_SH3UW, 64'hFFFF_FFFF_0000_0001, 64'd2);
        check("R6", result, 64'd10, "sh3add.uw drops upper half");
        apply(OP_SRAW, 64'h0000_0000_8000_0000, 64'd4);
        check("R4", result, 64'hFFFF_FFFF_F800_0000, "sraw fills from bit 31");

        // Every operation under corner and pseudo-random operands.
        for (int op = 0; op < NOPS; op++) begin
            for (int k = 0; k < 24; k++) begin
                logic [63:0] x, y;
                case (k)
                    0: begin x = 64'd0; y = 64'd0; end
                    1: begin x = '1; y = '1; end
                    2: begin x = 64'h8000_0000_0000_0000; y = 64'd1; end
                    3: begin x = 64'h7FFF_FFFF_FFFF_FFFF; y = 64'h8000_0000_0000_0000; end
                    4: begin x = 64'h0000_0000_0000_0080; y = 64'd63; end
                    5: begin x = 64'h1234_5678_8000_0000; y = 64'd31; end
                    default: begin x = {$urandom, $urandom}; y = {$urandom, $urandom}; end
                endcase
                apply(op, x, y);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule